// File: doc/BRIEF.md
# Copy Authorization and Block Protection Unit

This unit sits between the command decoder of a serial EEPROM front end and its nonvolatile array. When the host finishes a scratchpad-to-array copy request, it has sent three authorization bytes. The unit compares them with the live target-address and ending-offset/status registers. It accepts the copy only when the scratchpad is known good, no memory read has come in since the last scratchpad write, and the target is not copy protected. On acceptance it emits a one-cycle start strobe, raises the authorization-accepted flag and runs a self-timed programming window. The window length is a parameter counted in clock cycles.

The unit also decodes the protection bytes of the register page into a per-block mode for the scratchpad logic. For the current target address it reports whether the byte may be changed and whether the byte lies in a block that only allows bits to be cleared. A protection or lock byte that holds one of the two guard codes locks itself. The block lock copy-protects only blocks that are in write-protect mode. The page lock copy-protects the register page. The factory page and everything above it can never be written.

Top module: `copy_auth_unit`

## Requirements
- R1: A copy starts (`copy_start` high for one cycle, in the cycle after `auth_valid`) only if `auth_b0` equals `tgt_addr[7:0]`, `auth_b1` equals `tgt_addr[15:8]` and `auth_b2` equals `es_in`. A difference in any single bit rejects the request.
- R2: A request made while `pf_in` or `bs_in` is high is rejected.
- R3: Each block's mode is decoded from protection byte n (`prot_bytes[8n+7:8n]`) onto `blk_mode[2n+1:2n]`: 55h gives 01 (write protected), AAh gives 10 (clear-only), and every other value gives 00 (open).
- R4: Data memory covers addresses 0 to NBLK*256-1, and block n covers 256n to 256n+255. A request into a write-protected block is rejected when `blk_lock_byte` is 55h or AAh. With any other lock value, such a request is accepted so that the same data can be rewritten. Open and clear-only blocks ignore the block lock.
- R5: The register page covers addresses NBLK*256 to NBLK*256+31. Requests to it are rejected exactly when `pg_lock_byte` is 55h or AAh.
- R6: Requests at address NBLK*256+32 or above are always rejected, and `byte_ro` is 1 there.
- R7: A `mem_rd_evt` since the most recent `wr_sp_evt` makes requests fail. The same applies from reset until the first `wr_sp_evt`.
- R8: `aa_flag` is set by an accepted copy and cleared by `wr_sp_evt`. A rejected request leaves it unchanged.
- R9: After acceptance, `prog_busy` is high for exactly PROG_CYCLES cycles, and `xfer_status` reads 0 during that time and 1 at all other times, including after a rejection. A request made while busy is ignored.
- R10: `byte_ro` is 1 in the following cases:
  - a data byte in a write-protected block;
  - register-page offset n < NBLK whose protection byte holds 55h/AAh;
  - offset 30 when `blk_lock_byte` holds a guard code;
  - offset 31 and offsets NBLK..29 when `pg_lock_byte` holds a guard code.
- R11: `tgt_eprom` is 1 exactly when the target is a data byte in a clear-only block.
- R12: After reset, `copy_start`, `aa_flag` and `prog_busy` are 0 and `xfer_status` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_addr | input | 16 | Live target address register |
| es_in | input | 8 | Live ending-offset/status register |
| pf_in | input | 1 | Partial/invalid scratchpad flag |
| bs_in | input | 1 | Bad-sequence flag |
| wr_sp_evt | input | 1 | Scratchpad write command completed |
| mem_rd_evt | input | 1 | A memory read command was issued |
| auth_valid | input | 1 | Authorization bytes are complete (one-cycle strobe) |
| auth_b0 | input | 8 | First authorization byte |
| auth_b1 | input | 8 | Second authorization byte |
| auth_b2 | input | 8 | Third authorization byte |
| prot_bytes | input | 8*NBLK | Per-block protection bytes, block n in bits 8n+7:8n |
| blk_lock_byte | input | 8 | Block lock byte (page offset 30) |
| pg_lock_byte | input | 8 | Page lock byte (page offset 31) |
| copy_start | output | 1 | One-cycle strobe that commits the scratchpad |
| aa_flag | output | 1 | Authorization-accepted flag |
| prog_busy | output | 1 | Programming window running |
| xfer_status | output | 1 | 0 while programming, 1 otherwise |
| blk_mode | output | 2*NBLK | Decoded mode of each block |
| byte_ro | output | 1 | Target byte cannot be changed |
| tgt_eprom | output | 1 | Target lies in a clear-only block |

## Verification
The assertions assume that `auth_valid` is a single-cycle strobe and that the authorization bytes, target registers and flags are stable in the cycle it is sampled. They also assume the register-page bytes are driven from time zero. The stimulus changes every input on the falling edge and pulses each event for exactly one cycle. It never raises `wr_sp_evt`, `mem_rd_evt` and `auth_valid` in the same cycle, and it waits for each programming window to close before the next request, except in the single test that probes a request made while busy.

// File: rtl/cau_pkg.sv
package cau_pkg;

    typedef enum logic [1:0] {
        BM_OPEN   = 2'b00,
        BM_LOCKED = 2'b01,
        BM_OTP    = 2'b10
    } blk_mode_e;

    localparam logic [7:0] GUARD_WP  = 8'h55;
    localparam logic [7:0] GUARD_OTP = 8'hAA;

    localparam int unsigned BLK_BYTES  = 256;
    localparam int unsigned PAGE_BYTES = 32;

    typedef struct packed {
        logic copy_start;
        logic aa;
        logic stale;
    } ctl_state_t;

    function automatic logic is_guard(input logic [7:0] b);
        return (b == GUARD_WP) || (b == GUARD_OTP);
    endfunction

    function automatic blk_mode_e decode_mode(input logic [7:0] b);
        blk_mode_e m;
        if (b == GUARD_WP)       m = BM_LOCKED;
        else if (b == GUARD_OTP) m = BM_OTP;
        else                     m = BM_OPEN;
        return m;
    endfunction

endpackage

// File: rtl/cau_mode_decode.sv
module cau_mode_decode
    import cau_pkg::*;
#(
    parameter int unsigned NBLK = 10
) (
    input  logic [8*NBLK-1:0] prot_bytes,
    output logic [2*NBLK-1:0] blk_mode
);

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        blk_mode_e mode_g;
        assign mode_g             = decode_mode(prot_bytes[8*g +: 8]);
        assign blk_mode[2*g +: 2] = mode_g;
    end

endmodule

// File: rtl/cau_target_check.sv
module cau_target_check
    import cau_pkg::*;
#(
    parameter int unsigned NBLK = 10
) (
    input  logic [15:0]       tgt_addr,
    input  logic [2*NBLK-1:0] blk_mode,
    input  logic [8*NBLK-1:0] prot_bytes,
    input  logic [7:0]        blk_lock_byte,
    input  logic [7:0]        pg_lock_byte,
    output logic              copy_prot,
    output logic              byte_ro,
    output logic              tgt_eprom
);

    localparam int unsigned DATA_END     = NBLK * BLK_BYTES;
    localparam int unsigned FAC_BASE     = DATA_END + PAGE_BYTES;
    localparam int unsigned BLK_SHIFT    = $clog2(BLK_BYTES);
    localparam int unsigned OFS_W        = $clog2(PAGE_BYTES);
    localparam int unsigned LOCK_BLK_OFS = PAGE_BYTES - 2;
    localparam int unsigned LOCK_PG_OFS  = PAGE_BYTES - 1;

    logic [31:0]      addr_w;
    logic [31:0]      blk_idx;
    logic [OFS_W-1:0] ofs;
    logic             in_data;
    logic             in_reg;
    logic [1:0]       mode_sel;
    logic             reg_ro;
    logic             blk_guard;
    logic             pg_guard;

    assign addr_w    = {16'b0, tgt_addr};
    assign blk_idx   = addr_w >> BLK_SHIFT;
    assign ofs       = tgt_addr[OFS_W-1:0];
    assign in_data   = addr_w < 32'(DATA_END);
    assign in_reg    = !in_data && (addr_w < 32'(FAC_BASE));
    assign blk_guard = is_guard(blk_lock_byte);
    assign pg_guard  = is_guard(pg_lock_byte);

    always_comb begin
        mode_sel = BM_OPEN;
        for (int i = 0; i < NBLK; i++) begin
            if (blk_idx == 32'(i)) mode_sel = blk_mode[2*i +: 2];
        end
    end

    always_comb begin
        reg_ro = pg_guard;
        for (int i = 0; i < NBLK; i++) begin
            if (int'(ofs) == i) reg_ro = is_guard(prot_bytes[8*i +: 8]);
        end
        if (int'(ofs) == int'(LOCK_BLK_OFS)) reg_ro = blk_guard;
        if (int'(ofs) == int'(LOCK_PG_OFS))  reg_ro = pg_guard;
    end

    always_comb begin
        if (in_data) begin
            copy_prot = (mode_sel == BM_LOCKED) && blk_guard;
            byte_ro   = (mode_sel == BM_LOCKED);
            tgt_eprom = (mode_sel == BM_OTP);
        end else if (in_reg) begin
            copy_prot = pg_guard;
            byte_ro   = reg_ro;
            tgt_eprom = 1'b0;
        end else begin
            copy_prot = 1'b1;
            byte_ro   = 1'b1;
            tgt_eprom = 1'b0;
        end
    end

endmodule

// File: rtl/cau_prog_timer.sv
module cau_prog_timer #(
    parameter int unsigned CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/copy_auth_unit.sv
module copy_auth_unit
    import cau_pkg::*;
#(
    parameter int unsigned NBLK        = 10,
    parameter int unsigned PROG_CYCLES = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       tgt_addr,
    input  logic [7:0]        es_in,
    input  logic              pf_in,
    input  logic              bs_in,
    input  logic              wr_sp_evt,
    input  logic              mem_rd_evt,
    input  logic              auth_valid,
    input  logic [7:0]        auth_b0,
    input  logic [7:0]        auth_b1,
    input  logic [7:0]        auth_b2,
    input  logic [8*NBLK-1:0] prot_bytes,
    input  logic [7:0]        blk_lock_byte,
    input  logic [7:0]        pg_lock_byte,
    output logic              copy_start,
    output logic              aa_flag,
    output logic              prog_busy,
    output logic              xfer_status,
    output logic [2*NBLK-1:0] blk_mode,
    output logic              byte_ro,
    output logic              tgt_eprom
);

    ctl_state_t st_d;
    ctl_state_t st_q;
    logic       copy_prot;
    logic       bytes_match;
    logic       grant;

    cau_mode_decode #(.NBLK(NBLK)) u_mode (
        .prot_bytes (prot_bytes),
        .blk_mode   (blk_mode)
    );

    cau_target_check #(.NBLK(NBLK)) u_tgt (
        .tgt_addr      (tgt_addr),
        .blk_mode      (blk_mode),
        .prot_bytes    (prot_bytes),
        .blk_lock_byte (blk_lock_byte),
        .pg_lock_byte  (pg_lock_byte),
        .copy_prot     (copy_prot),
        .byte_ro       (byte_ro),
        .tgt_eprom     (tgt_eprom)
    );

    cau_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (grant),
        .busy  (prog_busy)
    );

    assign bytes_match = (auth_b0 == tgt_addr[7:0]) &&
                         (auth_b1 == tgt_addr[15:8]) &&
                         (auth_b2 == es_in);

    assign grant = auth_valid && bytes_match && !pf_in && !bs_in &&
                   !st_q.stale && !copy_prot && !prog_busy;

    always_comb begin
        st_d            = st_q;
        st_d.copy_start = grant;
        if (mem_rd_evt)     st_d.stale = 1'b1;
        else if (wr_sp_evt) st_d.stale = 1'b0;
        if (grant)          st_d.aa = 1'b1;
        else if (wr_sp_evt) st_d.aa = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.copy_start <= 1'b0;
            st_q.aa         <= 1'b0;
            st_q.stale      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign copy_start  = st_q.copy_start;
    assign aa_flag     = st_q.aa;
    assign xfer_status = !prog_busy;

endmodule

// File: rtl/cau_checker.sv
module cau_checker #(
    parameter int unsigned NBLK = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       tgt_addr,
    input logic [7:0]        es_in,
    input logic              pf_in,
    input logic              bs_in,
    input logic              wr_sp_evt,
    input logic              mem_rd_evt,
    input logic              auth_valid,
    input logic [7:0]        auth_b0,
    input logic [7:0]        auth_b1,
    input logic [7:0]        auth_b2,
    input logic              copy_prot,
    input logic              copy_start,
    input logic              aa_flag,
    input logic              prog_busy,
    input logic [2*NBLK-1:0] blk_mode,
    input logic              byte_ro
);

    localparam int unsigned FAC_BASE = NBLK * 256 + 32;

    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start |-> $past(auth_valid)); // R1

    AST_START_BYTES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start |-> $past(auth_b0 == tgt_addr[7:0] && auth_b1 == tgt_addr[15:8] && auth_b2 == es_in)); // R1

    AST_START_FLAGS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start |-> $past(!pf_in && !bs_in)); // R2

    AST_START_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start |-> $past(!copy_prot)); // R4

    AST_FACTORY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ({16'b0, tgt_addr} >= 32'(FAC_BASE)) |-> (byte_ro && copy_prot)); // R6

    AST_READ_BLOCKS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_evt ##1 !wr_sp_evt |=> !copy_start); // R7

    AST_AA_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aa_flag) |-> copy_start); // R8

    AST_AA_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sp_evt && !auth_valid |=> !aa_flag); // R8

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start |-> prog_busy); // R9

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start |=> !copy_start); // R9

    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NBLK; i++) begin
                AST_MODE_LEGAL: assert (blk_mode[2*i +: 2] != 2'b11); // R3
            end
        end
    end

endmodule

bind copy_auth_unit cau_checker #(.NBLK(NBLK)) u_cau_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tgt_addr   (tgt_addr),
    .es_in      (es_in),
    .pf_in      (pf_in),
    .bs_in      (bs_in),
    .wr_sp_evt  (wr_sp_evt),
    .mem_rd_evt (mem_rd_evt),
    .auth_valid (auth_valid),
    .auth_b0    (auth_b0),
    .auth_b1    (auth_b1),
    .auth_b2    (auth_b2),
    .copy_prot  (copy_prot),
    .copy_start (copy_start),
    .aa_flag    (aa_flag),
    .prog_busy  (prog_busy),
    .blk_mode   (blk_mode),
    .byte_ro    (byte_ro)
);

// File: tb/copy_auth_unit_bench.sv
module copy_auth_unit_bench;

    localparam int unsigned NB  = 4;
    localparam int unsigned PC  = 12;
    localparam int unsigned DE  = NB * 256;
    localparam int unsigned FAC = DE + 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       tgt_addr = '0;
    logic [7:0]        es_in = '0;
    logic              pf_in = 1'b0;
    logic              bs_in = 1'b0;
    logic              wr_sp_evt = 1'b0;
    logic              mem_rd_evt = 1'b0;
    logic              auth_valid = 1'b0;
    logic [7:0]        auth_b0 = '0;
    logic [7:0]        auth_b1 = '0;
    logic [7:0]        auth_b2 = '0;
    logic [8*NB-1:0]   prot_bytes = '0;
    logic [7:0]        blk_lock_byte = '0;
    logic [7:0]        pg_lock_byte = '0;
    logic              copy_start;
    logic              aa_flag;
    logic              prog_busy;
    logic              xfer_status;
    logic [2*NB-1:0]   blk_mode;
    logic              byte_ro;
    logic              tgt_eprom;

    int  n_vec = 0;
    int  n_bad = 0;
    logic stale_m = 1'b1;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    copy_auth_unit #(.NBLK(NB), .PROG_CYCLES(PC)) u_copy_auth_unit (
        .clk(clk), .rst_n(rst_n), .tgt_addr(tgt_addr), .es_in(es_in),
        .pf_in(pf_in), .bs_in(bs_in), .wr_sp_evt(wr_sp_evt), .mem_rd_evt(mem_rd_evt),
        .auth_valid(auth_valid), .auth_b0(auth_b0), .auth_b1(auth_b1), .auth_b2(auth_b2),
        .prot_bytes(prot_bytes), .blk_lock_byte(blk_lock_byte), .pg_lock_byte(pg_lock_byte),
        .copy_start(copy_start), .aa_flag(aa_flag), .prog_busy(prog_busy),
        .xfer_status(xfer_status), .blk_mode(blk_mode), .byte_ro(byte_ro), .tgt_eprom(tgt_eprom)
    );

    function automatic logic guard(input logic [7:0] b);
        return b == 8'h55 || b == 8'hAA;
    endfunction

    function automatic logic [1:0] mode_of(input logic [7:0] b);
        return (b == 8'h55) ? 2'b01 : (b == 8'hAA) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [1:0] blk_mode_at(input int a);
        return mode_of(prot_bytes[8*(a/256) +: 8]);
    endfunction

    function automatic logic exp_prot(input int a);
        if (a < DE)  return blk_mode_at(a) == 2'b01 && guard(blk_lock_byte);
        if (a < FAC) return guard(pg_lock_byte);
        return 1'b1;
    endfunction

    function automatic logic exp_ro(input int a);
        int off;
        if (a < DE) return blk_mode_at(a) == 2'b01;
        if (a >= FAC) return 1'b1;
        off = a - DE;
        if (off < NB)  return guard(prot_bytes[8*off +: 8]);
        if (off == 30) return guard(blk_lock_byte);
        return guard(pg_lock_byte);
    endfunction

    function automatic logic exp_eprom(input int a);
        return a < DE && blk_mode_at(a) == 2'b10;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic scratch_write();
        wr_sp_evt = 1'b1;
        @(negedge clk);
        wr_sp_evt = 1'b0;
        stale_m = 1'b0;
    endtask

    task automatic mem_read();
        mem_rd_evt = 1'b1;
        @(negedge clk);
        mem_rd_evt = 1'b0;
        stale_m = 1'b1;
    endtask

    task automatic attempt(input logic [15:0] a, input logic [7:0] es,
                           input logic [23:0] auth, input logic pf, input logic bs,
                           input string req);
        logic exp;
        int   cnt;
        tgt_addr = a; es_in = es; pf_in = pf; bs_in = bs;
        {auth_b2, auth_b1, auth_b0} = auth;
        exp = (auth == {es, a}) && !pf && !bs && !stale_m && !exp_prot(int'(a));
        auth_valid = 1'b1;
        @(negedge clk);
        auth_valid = 1'b0;
        chk(req, {31'b0, copy_start}, {31'b0, exp});
        if (exp) begin
            chk("R8 aa after accept", {31'b0, aa_flag}, 32'd1);
            cnt = 0;
            while (prog_busy) begin
                if (xfer_status !== 1'b0) chk("R9 status while busy", {31'b0, xfer_status}, 32'd0);
                cnt++;
                @(negedge clk);
            end
            chk("R9 busy length", cnt, PC);
        end
        chk("R9 status idle", {31'b0, xfer_status}, 32'd1);
        pf_in = 1'b0; bs_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  codes [4];
        logic [7:0]  locks [4];
        codes[0] = 8'h00; codes[1] = 8'h55; codes[2] = 8'hAA; codes[3] = 8'h3C;
        locks[0] = 8'h00; locks[1] = 8'h55; locks[2] = 8'hAA; locks[3] = 8'h12;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 copy_start", {31'b0, copy_start}, 0);
        chk("R12 aa", {31'b0, aa_flag}, 0);
        chk("R12 busy", {31'b0, prog_busy}, 0);
        chk("R12 status", {31'b0, xfer_status}, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: no scratchpad write since reset
        attempt(16'h0010, 8'h1F, {8'h1F, 16'h0010}, 1'b0, 1'b0, "R7 stale after reset");

        // R3: exhaustive byte decode for every block
        for (int b = 0; b < NB; b++) begin
            for (int c = 0; c < 256; c++) begin
                prot_bytes = '0;
                prot_bytes[8*b +: 8] = 8'(c);
                #1;
                chk("R3 mode decode", {30'b0, blk_mode[2*b +: 2]}, {30'b0, mode_of(8'(c))});
            end
        end
        prot_bytes = '0;
        @(negedge clk);

        // R4 R10 R11: data blocks across modes and block-lock values
        scratch_write();
        for (int b = 0; b < NB; b++) begin
            for (int c = 0; c < 4; c++) begin
                for (int l = 0; l < 4; l++) begin
                    prot_bytes = '0;
                    prot_bytes[8*b +: 8] = codes[c];
                    blk_lock_byte = locks[l];
                    a = 16'(b * 256 + 8 * b + 5);
                    tgt_addr = a;
                    #1;
                    chk("R10 data byte_ro", {31'b0, byte_ro}, {31'b0, exp_ro(int'(a))});
                    chk("R11 tgt_eprom", {31'b0, tgt_eprom}, {31'b0, exp_eprom(int'(a))});
                    attempt(a, 8'(c * 4 + l), {8'(c * 4 + l), a}, 1'b0, 1'b0, "R4 data block copy");
                end
            end
        end
        blk_lock_byte = '0;

        // R5 R10: register page offsets under page-lock values
        prot_bytes = {8'h3C, 8'hAA, 8'h55, 8'h00};
        for (int p = 0; p < 3; p++) begin
            pg_lock_byte  = locks[p];
            blk_lock_byte = (p == 1) ? 8'hAA : 8'h07;
            for (int off = 0; off < 32; off++) begin
                a = 16'(DE + off);
                tgt_addr = a;
                #1;
                chk("R10 page byte_ro", {31'b0, byte_ro}, {31'b0, exp_ro(int'(a))});
                chk("R11 page not eprom", {31'b0, tgt_eprom}, 0);
                attempt(a, 8'(off), {8'(off), a}, 1'b0, 1'b0, "R5 register page copy");
            end
        end
        pg_lock_byte = '0; blk_lock_byte = '0; prot_bytes = '0;

        // R6: factory page and beyond
        for (int k = 0; k < 35; k++) begin
            a = (k < 32) ? 16'(FAC + k) : (k == 32) ? 16'(FAC + 32) : (k == 33) ? 16'h8000 : 16'hFFFF;
            tgt_addr = a;
            #1;
            chk("R6 byte_ro", {31'b0, byte_ro}, 1);
            attempt(a, 8'h00, {8'h00, a}, 1'b0, 1'b0, "R6 read-only region copy");
        end

        // R1: each single-bit difference rejects, exact match accepts
        for (int bit_i = 0; bit_i < 24; bit_i++) begin
            attempt(16'h0123, 8'h1F, {8'h1F, 16'h0123} ^ (24'd1 << bit_i), 1'b0, 1'b0, "R1 mismatch reject");
        end
        attempt(16'h0123, 8'h1F, {8'h1F, 16'h0123}, 1'b0, 1'b0, "R1 exact match");

        // R2: flags
        attempt(16'h0200, 8'h05, {8'h05, 16'h0200}, 1'b1, 1'b0, "R2 pf set");
        attempt(16'h0200, 8'h05, {8'h05, 16'h0200}, 1'b0, 1'b1, "R2 bs set");
        attempt(16'h0200, 8'h05, {8'h05, 16'h0200}, 1'b1, 1'b1, "R2 both set");
        attempt(16'h0200, 8'h05, {8'h05, 16'h0200}, 1'b0, 1'b0, "R2 flags clear");

        // R8: write clears aa, reject leaves it
        scratch_write();
        chk("R8 aa cleared by write", {31'b0, aa_flag}, 0);
        attempt(16'h0200, 8'h05, {8'h06, 16'h0200}, 1'b0, 1'b0, "R8 reject");
        chk("R8 aa kept clear after reject", {31'b0, aa_flag}, 0);

        // R7: intervening read
        mem_read();
        attempt(16'h0300, 8'h01, {8'h01, 16'h0300}, 1'b0, 1'b0, "R7 read since write");
        scratch_write();
        attempt(16'h0300, 8'h01, {8'h01, 16'h0300}, 1'b0, 1'b0, "R7 write after read");

        // R9: request during busy is ignored
        tgt_addr = 16'h0040; es_in = 8'h02;
        {auth_b2, auth_b1, auth_b0} = {8'h02, 16'h0040};
        auth_valid = 1'b1;
        @(negedge clk);
        chk("R9 first accepted", {31'b0, copy_start}, 1);
        @(negedge clk);
        auth_valid = 1'b0;
        chk("R9 busy request ignored", {31'b0, copy_start}, 0);
        chk("R9 status busy", {31'b0, xfer_status}, 0);
        repeat (PC - 1) @(negedge clk);
        chk("R9 window ends", {31'b0, prog_busy}, 0);
        chk("R9 status after window", {31'b0, xfer_status}, 1);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule